// File: doc/BRIEF.md
# Constant-On-Time Gate Pulse Sequencer

This block drives the high-side and low-side switch commands of a synchronous buck regulator that uses constant-on-time control. It starts a new conduction pulse only when the feedback comparator asks for more energy, the valley current is under its limit, and the minimum off interval has passed. The pulse width is a cycle count that other logic computes from the input and output voltages. The block raises that count to a floor when it is too short. It inserts a fixed dead interval on every edge between the two switches.

Two conduction modes are supported. In the automatic mode, an inductor zero-crossing indication switches the low side off until the next pulse, so the regulator skips cycles at light load. In the forced mode, that indication is ignored and the low side conducts for the whole off interval. A disable input from the protection logic overrides everything. It can hold both switches off, or it can hold only the low side on.

Top module: `cot_pulse_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, both `hs_o` and `ls_o` are low until a pulse is requested.
- R2: With `cmp_hi_i` low, no pulse starts. When `cmp_hi_i` rises with `ilim_i` low and the off interval already expired, `hs_o` is high in the DEAD+1-th cycle after the cycle in which the request is first seen.
- R3: While `ilim_i` is high, no new pulse starts, even with `cmp_hi_i` high. After it falls, a pulse starts with the latency given in R2.
- R4: `hs_o` stays high for exactly max(`ton_cyc_i`, TON_MIN) cycles. A requested length of 0 gives TON_MIN.
- R5: `ton_cyc_i` is captured in the cycle that triggers a pulse. A change while the pulse runs affects only the following pulse.
- R6: Between two pulses, `hs_o` is low for at least TOFF_MIN+DEAD cycles. While the request is held, it is low for exactly that many cycles.
- R7: `hs_o` and `ls_o` are never high together. After `hs_o` falls, `ls_o` stays low for DEAD cycles before it rises. Before `hs_o` rises, `ls_o` has been low for DEAD cycles.
- R8: In the automatic mode (`force_pwm_i` = 0), `zcross_i` high while the low side conducts turns `ls_o` off on the next cycle. `ls_o` then stays off until the next pulse, even after `zcross_i` falls.
- R9: In the forced mode (`force_pwm_i` = 1), `zcross_i` has no effect. `ls_o` stays high from the end of the dead interval until the next pulse.
- R10: While `gate_off_i` is high with `ls_force_i` low, both outputs are low in that same cycle, and any running pulse is dropped.
- R11: While `gate_off_i` is high with `ls_force_i` high, `ls_o` is high and `hs_o` is low in that same cycle.
- R12: After `gate_off_i` falls, the off interval starts again. With the request held, `hs_o` rises TOFF_MIN+DEAD cycles after the last clock edge that saw `gate_off_i` high, and `ls_o` is low in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi_i | input | 1 | Feedback comparator asks for a pulse |
| ilim_i | input | 1 | Valley current at or above the limit |
| zcross_i | input | 1 | Inductor current has reached zero |
| force_pwm_i | input | 1 | 1 = forced mode, 0 = automatic mode |
| ton_cyc_i | input | TON_W | Requested on-time in clock cycles |
| gate_off_i | input | 1 | Protection disable of both switches |
| ls_force_i | input | 1 | With disable high, hold the low side on |
| hs_o | output | 1 | High-side switch command |
| ls_o | output | 1 | Low-side switch command |

## Verification
The assertions assume that every input is already synchronous to `clk` and changes only between clock edges. They also assume that `gate_off_i` is the only path by which a pulse can end early. For that reason, the minimum-width and dead-interval properties are masked in any cycle where the disable is high or was high one cycle before. The stimulus changes inputs just after the falling edge, holds the disable for several cycles at a time, and raises `ls_force_i` only while the disable is high. The parameters stay at their defaults: DEAD of at least 1 and TON_MIN of at least 1.

// File: rtl/cot_pkg.sv
package cot_pkg;

  // Sequencer phases: both off, dead before high side, high side on,
  // dead after high side, low side on.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_ON    = 3'd2,
    ST_TRAIL = 3'd3,
    ST_LOW   = 3'd4
  } cot_state_e;

endpackage

// File: rtl/cot_oneshot.sv
// Loadable down-counter; done while the count is zero.
module cot_oneshot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/cot_gate_seq.sv
// Phase sequencer: trigger, dead intervals, mode-dependent low-side end.
module cot_gate_seq
  import cot_pkg::*;
#(
  parameter int unsigned TON_W   = 10,
  parameter int unsigned TON_MIN = 11,
  parameter int unsigned DEAD    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             off_done_i,
  input  logic             on_done_i,
  input  logic             zc_i,
  input  logic             force_pwm_i,
  input  logic             gate_off_i,
  input  logic [TON_W-1:0] ton_i,
  output cot_state_e       state_o,
  output logic             on_load_o,
  output logic [TON_W-1:0] on_val_o,
  output logic             off_load_o
);

  localparam int unsigned     DW        = (DEAD > 1) ? $clog2(DEAD) : 1;
  localparam logic [DW-1:0]    DEAD_LD   = DW'(DEAD - 1);
  localparam logic [TON_W-1:0] TON_MIN_C = TON_W'(TON_MIN);

  cot_state_e       st_q, st_d;
  logic [DW-1:0]    dcnt_q, dcnt_d;
  logic [TON_W-1:0] ton_q, ton_d;
  logic [TON_W-1:0] ton_eff;
  logic             fire;

  assign ton_eff = (ton_i < TON_MIN_C) ? TON_MIN_C : ton_i;
  assign fire    = req_i && off_done_i;

  always_comb begin
    st_d       = st_q;
    dcnt_d     = dcnt_q;
    ton_d      = ton_q;
    on_load_o  = 1'b0;
    off_load_o = 1'b0;
    if (gate_off_i) begin
      st_d       = ST_IDLE;
      dcnt_d     = '0;
      off_load_o = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE, ST_LOW: begin
          if (fire) begin
            st_d   = ST_LEAD;
            dcnt_d = DEAD_LD;
            ton_d  = ton_eff;
          end else if ((st_q == ST_LOW) && !force_pwm_i && zc_i) begin
            st_d = ST_IDLE;
          end
        end
        ST_LEAD: begin
          if (dcnt_q == '0) begin
            st_d      = ST_ON;
            on_load_o = 1'b1;
          end else begin
            dcnt_d = dcnt_q - 1'b1;
          end
        end
        ST_ON: begin
          if (on_done_i) begin
            st_d       = ST_TRAIL;
            dcnt_d     = DEAD_LD;
            off_load_o = 1'b1;
          end
        end
        ST_TRAIL: begin
          if (dcnt_q == '0) begin
            st_d = ST_LOW;
          end else begin
            dcnt_d = dcnt_q - 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dcnt_q <= '0;
      ton_q  <= TON_MIN_C;
    end else begin
      st_q   <= st_d;
      dcnt_q <= dcnt_d;
      if (fire) begin
        ton_q <= ton_d;
      end
    end
  end

  assign state_o  = st_q;
  assign on_val_o = ton_q - 1'b1;

endmodule

// File: rtl/cot_pulse_ctrl.sv
module cot_pulse_ctrl
  import cot_pkg::*;
#(
  parameter int unsigned TON_W    = 10,
  parameter int unsigned TON_MIN  = 11,
  parameter int unsigned TOFF_MIN = 45,
  parameter int unsigned DEAD     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_hi_i,
  input  logic             ilim_i,
  input  logic             zcross_i,
  input  logic             force_pwm_i,
  input  logic [TON_W-1:0] ton_cyc_i,
  input  logic             gate_off_i,
  input  logic             ls_force_i,
  output logic             hs_o,
  output logic             ls_o
);

  localparam int unsigned     OFF_W   = $clog2(TOFF_MIN + 1);
  localparam logic [OFF_W-1:0] OFF_LD = OFF_W'(TOFF_MIN - 1);

  cot_state_e       state;
  logic             on_load, off_load, on_done, off_done;
  logic [TON_W-1:0] on_val;

  cot_gate_seq #(
    .TON_W  (TON_W),
    .TON_MIN(TON_MIN),
    .DEAD   (DEAD)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (cmp_hi_i && !ilim_i),
    .off_done_i (off_done),
    .on_done_i  (on_done),
    .zc_i       (zcross_i),
    .force_pwm_i(force_pwm_i),
    .gate_off_i (gate_off_i),
    .ton_i      (ton_cyc_i),
    .state_o    (state),
    .on_load_o  (on_load),
    .on_val_o   (on_val),
    .off_load_o (off_load)
  );

  cot_oneshot #(.W(TON_W)) u_on_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(on_load),
    .val_i (on_val),
    .done_o(on_done)
  );

  cot_oneshot #(.W(OFF_W)) u_off_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(off_load),
    .val_i (OFF_LD),
    .done_o(off_done)
  );

  assign hs_o = !gate_off_i && (state == ST_ON);
  assign ls_o = gate_off_i ? ls_force_i : (state == ST_LOW);

endmodule

// File: rtl/cot_pulse_ctrl_chk.sv
module cot_pulse_ctrl_chk #(
  parameter int unsigned TON_MIN  = 11,
  parameter int unsigned TOFF_MIN = 45,
  parameter int unsigned DEAD     = 2
) (
  input logic clk,
  input logic rst_n,
  input logic gate_off_i,
  input logic ls_force_i,
  input logic hs_o,
  input logic ls_o
);

  localparam int unsigned GAP = TOFF_MIN + DEAD;
  localparam int unsigned TOP = (GAP > TON_MIN) ? GAP : TON_MIN;
  localparam int unsigned CW  = $clog2(TOP + 1);
  localparam logic [CW-1:0] GAP_C  = CW'(GAP);
  localparam logic [CW-1:0] TON_C  = CW'(TON_MIN);
  localparam logic [CW-1:0] DEAD_C = CW'(DEAD);

  logic [CW-1:0] hs_lo_cnt, ls_lo_cnt, hs_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_lo_cnt <= GAP_C;
      ls_lo_cnt <= GAP_C;
      hs_hi_cnt <= '0;
    end else begin
      if (hs_o) hs_lo_cnt <= '0;
      else if (hs_lo_cnt != GAP_C) hs_lo_cnt <= hs_lo_cnt + 1'b1;
      if (ls_o) ls_lo_cnt <= '0;
      else if (ls_lo_cnt != GAP_C) ls_lo_cnt <= ls_lo_cnt + 1'b1;
      if (!hs_o) hs_hi_cnt <= '0;
      else if (hs_hi_cnt != TON_C) hs_hi_cnt <= hs_hi_cnt + 1'b1;
    end
  end

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_o && ls_o));

  a_r7_dead_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_o) && !gate_off_i) |-> (hs_lo_cnt >= DEAD_C));

  a_r7_dead_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_o) |-> (ls_lo_cnt >= DEAD_C));

  a_r6_min_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_o) |-> (hs_lo_cnt >= GAP_C));

  a_r4_min_on: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_o) && !gate_off_i && !$past(gate_off_i)) |-> (hs_hi_cnt >= TON_C));

  a_r10_disable: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off_i |-> (!hs_o && (ls_o == ls_force_i)));

endmodule

bind cot_pulse_ctrl cot_pulse_ctrl_chk #(
  .TON_MIN (TON_MIN),
  .TOFF_MIN(TOFF_MIN),
  .DEAD    (DEAD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_off_i(gate_off_i),
  .ls_force_i(ls_force_i),
  .hs_o      (hs_o),
  .ls_o      (ls_o)
);

// File: tb/sim_cot_pulse_ctrl.sv
module sim_cot_pulse_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int TON_W      = 10;
  localparam int TON_MIN    = 11;
  localparam int TOFF_MIN   = 45;
  localparam int DEAD       = 2;
  localparam int GAP        = TOFF_MIN + DEAD;

  logic clk = 1'b0;
  logic rst_n, cmp, ilim, zc, fpwm, goff, lsf;
  logic [TON_W-1:0] ton;
  logic hs_o, ls_o;

  int checks = 0;
  int errors = 0;
  int overlap = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cot_pulse_ctrl #(
    .TON_W(TON_W), .TON_MIN(TON_MIN), .TOFF_MIN(TOFF_MIN), .DEAD(DEAD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_hi_i(cmp), .ilim_i(ilim), .zcross_i(zc),
    .force_pwm_i(fpwm), .ton_cyc_i(ton), .gate_off_i(goff), .ls_force_i(lsf),
    .hs_o(hs_o), .ls_o(ls_o)
  );

  always @(negedge clk) if (rst_n && hs_o && ls_o) overlap++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_hs_high(input int lim, output int k);
    k = 0;
    while (k < lim) begin
      @(negedge clk);
      k++;
      if (hs_o) break;
    end
  endtask

  task automatic count_high(output int n);
    n = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!hs_o) break;
      n++;
    end
  endtask

  task automatic count_low(output int n);
    n = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (hs_o) break;
      n++;
    end
  endtask

  task automatic idle(input int n);
    cmp = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    int hi = 0;
    rst_n = 1'b0; cmp = 0; ilim = 0; zc = 0; fpwm = 1; goff = 0; lsf = 0;
    ton = TON_W'(20);
    repeat (3) @(negedge clk);
    chk("R1", "hs in reset", int'(hs_o), 0);
    chk("R1", "ls in reset", int'(ls_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "hs after reset", int'(hs_o), 0);
    chk("R1", "ls after reset", int'(ls_o), 0);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (hs_o) hi++;
    end
    chk("R2", "pulses with comparator low", hi, 0);
  endtask

  task automatic t_trigger;
    int k, n;
    idle(60);
    ton = TON_W'(20);
    cmp = 1'b1;
    wait_hs_high(20, k);
    chk("R2", "request to high-side latency", k, DEAD + 1);
    cmp = 1'b0;
    count_high(n);
  endtask

  task automatic t_width;
    int vals[5] = '{0, 5, 11, 12, 37};
    int k, n;
    foreach (vals[i]) begin
      idle(60);
      ton = TON_W'(vals[i]);
      cmp = 1'b1;
      wait_hs_high(20, k);
      cmp = 1'b0;
      count_high(n);
      chk("R4", $sformatf("width for request %0d", vals[i]), n,
          (vals[i] < TON_MIN) ? TON_MIN : vals[i]);
    end
  endtask

  task automatic t_gap_dead;
    int k, n;
    logic l1, l2;
    idle(60);
    fpwm = 1'b1; ton = TON_W'(20); cmp = 1'b1;
    wait_hs_high(20, k);
    count_high(n);
    chk("R7", "ls on first cycle after hs", int'(ls_o), 0);
    @(negedge clk);
    chk("R7", "ls on second cycle after hs", int'(ls_o), 0);
    @(negedge clk);
    chk("R7", "ls after dead interval", int'(ls_o), 1);
    n = 3; l1 = 1'b1; l2 = 1'b1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (hs_o) break;
      n++; l2 = l1; l1 = ls_o;
    end
    chk("R6", "high-side low interval", n, GAP);
    chk("R7", "ls one cycle before hs", int'(l1), 0);
    chk("R7", "ls two cycles before hs", int'(l2), 0);
    cmp = 1'b0;
    count_high(n);
  endtask

  task automatic t_ton_sample;
    int k, n;
    idle(60);
    fpwm = 1'b1; ton = TON_W'(30); cmp = 1'b1;
    wait_hs_high(20, k);
    ton = TON_W'(4);
    count_high(n);
    chk("R5", "running pulse keeps captured width", n, 30);
    count_low(n);
    chk("R6", "gap with request held", n, GAP);
    cmp = 1'b0;
    count_high(n);
    chk("R5", "next pulse uses new request", n, TON_MIN);
  endtask

  task automatic t_ilim;
    int k, n, hi;
    idle(60);
    fpwm = 1'b1; ton = TON_W'(20); cmp = 1'b1;
    wait_hs_high(20, k);
    ilim = 1'b1;
    count_high(n);
    hi = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (hs_o) hi++;
    end
    chk("R3", "pulses while current limit high", hi, 0);
    ilim = 1'b0;
    wait_hs_high(20, k);
    chk("R3", "latency after limit release", k, DEAD + 1);
    cmp = 1'b0;
    count_high(n);
  endtask

  task automatic t_auto_zc;
    int k, n;
    idle(60);
    fpwm = 1'b0; zc = 1'b0; ton = TON_W'(20); cmp = 1'b1;
    wait_hs_high(20, k);
    cmp = 1'b0;
    count_high(n);
    repeat (2) @(negedge clk);
    chk("R8", "ls on after dead interval", int'(ls_o), 1);
    repeat (3) @(negedge clk);
    chk("R8", "ls held without zero crossing", int'(ls_o), 1);
    zc = 1'b1;
    @(negedge clk);
    chk("R8", "ls off after zero crossing", int'(ls_o), 0);
    zc = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8", "ls stays off after crossing clears", int'(ls_o), 0);
    chk("R8", "hs stays off", int'(hs_o), 0);
  endtask

  task automatic t_forced_zc;
    int k, n, lo;
    idle(60);
    fpwm = 1'b1; zc = 1'b1; ton = TON_W'(20); cmp = 1'b1;
    wait_hs_high(20, k);
    cmp = 1'b0;
    count_high(n);
    repeat (2) @(negedge clk);
    lo = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ls_o) lo++;
    end
    chk("R9", "ls cycles high with crossing ignored", lo, 100);
    zc = 1'b0;
  endtask

  task automatic t_protect;
    int k, n;
    idle(60);
    fpwm = 1'b1; ton = TON_W'(40); cmp = 1'b1;
    wait_hs_high(20, k);
    repeat (5) @(negedge clk);
    goff = 1'b1; lsf = 1'b0;
    #1;
    chk("R10", "hs same cycle as disable", int'(hs_o), 0);
    chk("R10", "ls same cycle as disable", int'(ls_o), 0);
    @(negedge clk);
    chk("R10", "hs held off", int'(hs_o), 0);
    lsf = 1'b1;
    #1;
    chk("R11", "ls forced on", int'(ls_o), 1);
    chk("R11", "hs with ls forced", int'(hs_o), 0);
    repeat (5) @(negedge clk);
    chk("R11", "ls still forced", int'(ls_o), 1);
    @(negedge clk);
    goff = 1'b0; lsf = 1'b0;
    @(negedge clk);
    chk("R12", "ls after release", int'(ls_o), 0);
    wait_hs_high(200, k);
    chk("R12", "restart delay after release", k + 1, GAP);
    cmp = 1'b0;
    count_high(n);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_trigger();
    t_width();
    t_gap_dead();
    t_ton_sample();
    t_ilim();
    t_auto_zc();
    t_forced_zc();
    t_protect();
    idle(10);
    chk("R7", "cycles with both commands high", overlap, 0);
    finish_run();
  end

endmodule